// File: doc/BRIEF.md
# DMA Software Trigger Request Gate

This block sits between the peripheral request lines, the register bus and a multi-channel DMA engine. It keeps a software trigger word with one bit per channel. Software writes a 1 to a bit to start a transfer on that channel. For each channel, the block ORs the pending trigger bit with the channel's hardware request and presents the result to the engine.

When the engine reports that a channel has started, through a one-cycle activation strobe, the trigger bit for that channel clears. At the same moment the block records whether software caused the start. When the engine later signals completion, the acknowledge pulse goes back to the mapped peripheral only if the activation came from hardware. A peripheral that never raised a request therefore never sees an acknowledge it did not ask for.

Software can read the word back and poll it until a triggered channel has started. The channel count is a parameter, from 1 to 32.

Top module: `dma_swtrig_gate`

## Requirements
- R1: After reset, every trigger bit, every read-back bit and every acknowledge output is 0.
- R2: A register write with data bit n equal to 1, where n is below NUM_CH, sets trigger bit n. The read-back word shows bit n as 1 from the cycle after the write.
- R3: A data bit of 0 in a register write leaves the matching trigger bit unchanged.
- R4: Read-back bits at positions NUM_CH and above are always 0, and writes to those positions have no effect.
- R5: In the same cycle, the request to the engine for channel n is the OR of trigger bit n and hardware request line n.
- R6: An activation strobe on channel n clears trigger bit n, and the read-back word shows it cleared from the next cycle.
- R7: A write that sets bit n in the same cycle as channel n's activation strobe wins, and the bit stays 1.
- R8: A channel activated while its trigger bit is 0 is hardware-origin. Its completion pulse appears on the acknowledge output one cycle later.
- R9: A channel activated while its trigger bit is 1 is software-origin, even if its hardware request is also high. Its completion pulse is not forwarded. After that completion, the origin mark clears, so a later hardware activation acknowledges normally.
- R10: When completion arrives in the same cycle as activation, the trigger bit in that cycle decides the origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Write strobe for the trigger word |
| reg_wdata | input | 32 | Write data; bit n sets channel n |
| reg_rdata | output | 32 | Pending trigger bits; upper unused bits are 0 |
| hw_req | input | NUM_CH | Hardware request from each channel's mapped source |
| eng_req | output | NUM_CH | Merged request to the DMA engine |
| eng_active | input | NUM_CH | One-cycle strobe: the channel has gone active |
| eng_done | input | NUM_CH | One-cycle strobe: the channel's transfer has completed |
| src_ack | output | NUM_CH | Acknowledge pulse toward the mapped source |

## Verification
If a trigger bit is stuck or cleared wrongly, it shows up on both the read-back word and the engine request in the next cycle. A wrong origin mark stays hidden until that channel's completion pulse. It then appears as one missing or extra acknowledge, one cycle after completion. The bench therefore drives dense random activation and completion traffic, so that every origin mark is tested quickly. It also runs directed collisions of write with activation and of activation with completion.

// File: rtl/dma_swtrig_pkg.sv
package dma_swtrig_pkg;
  localparam int REG_W  = 32;
  localparam int MAX_CH = 32;
  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/swtrig_reg.sv
module swtrig_reg
  import dma_swtrig_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_word_t         wdata,
  input  logic [NUM_CH-1:0] active,
  output logic [NUM_CH-1:0] pend,
  output reg_word_t         rdata
);
  localparam int PAD_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] set_vec;

  assign set_vec = wr_en ? wdata[NUM_CH-1:0] : '0;

  // A set in the same cycle as the clearing strobe wins
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= set_vec | (pend & ~active);
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, pend};
    end else begin : g_full
      assign rdata = pend;
    end
  endgenerate

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      assert_write1_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[n]) |=> pend[n]);
      assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[n] && active[n]) |=> pend[n]);
      assert_active_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (active[n] && !(wr_en && wdata[n])) |=> !pend[n]);
      assert_zero_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!active[n] && !(wr_en && wdata[n])) |=> $stable(pend[n]));
    end
  endgenerate
endmodule

// File: rtl/origin_track.sv
module origin_track #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] active,
  input  logic [NUM_CH-1:0] done,
  output logic [NUM_CH-1:0] ack
);
  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic sw_mark;
      logic sw_now;

      // Origin of the activation that a completion belongs to
      assign sw_now = active[n] ? pend[n] : sw_mark;

      always_ff @(posedge clk) begin
        if (rst) begin
          sw_mark <= 1'b0;
          ack[n]  <= 1'b0;
        end else begin
          ack[n] <= done[n] & ~sw_now;
          if (done[n])        sw_mark <= 1'b0;
          else if (active[n]) sw_mark <= pend[n];
        end
      end

      assert_ack_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        ack[n] |-> $past(done[n]));
      assert_same_cycle_sw_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (active[n] && pend[n] && done[n]) |=> !ack[n]);
      assert_hw_same_cycle_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (active[n] && !pend[n] && done[n]) |=> ack[n]);
    end
  endgenerate
endmodule

// File: rtl/dma_swtrig_gate.sv
module dma_swtrig_gate
  import dma_swtrig_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] hw_req,
  output logic [NUM_CH-1:0] eng_req,
  input  logic [NUM_CH-1:0] eng_active,
  input  logic [NUM_CH-1:0] eng_done,
  output logic [NUM_CH-1:0] src_ack
);
  logic [NUM_CH-1:0] pend;

  swtrig_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .wdata  (reg_wdata),
    .active (eng_active),
    .pend   (pend),
    .rdata  (reg_rdata)
  );

  origin_track #(.NUM_CH(NUM_CH)) u_org (
    .clk    (clk),
    .rst    (rst),
    .pend   (pend),
    .active (eng_active),
    .done   (eng_done),
    .ack    (src_ack)
  );

  assign eng_req = pend | hw_req;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_top_chk
      assert_req_covers_trigger_R5: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[n] |-> eng_req[n]);
    end
  endgenerate
endmodule

// File: tb/dma_swtrig_gate_test.sv
module dma_swtrig_gate_test;
  localparam int NUM_CH = 8;
  localparam logic [31:0] CHMASK = (32'h1 << NUM_CH) - 32'h1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_CH-1:0] hw_req = '0, eng_req, eng_active = '0, eng_done = '0, src_ack;

  int checks = 0;
  int fails = 0;

  logic [31:0]       m_trig = '0;
  logic [NUM_CH-1:0] m_sw   = '0;
  logic [NUM_CH-1:0] m_ack  = '0;

  always #10 clk = ~clk;

  dma_swtrig_gate #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hw_req(hw_req), .eng_req(eng_req),
    .eng_active(eng_active), .eng_done(eng_done), .src_ack(src_ack)
  );

  // Behavioural reference, written from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_trig = '0; m_sw = '0; m_ack = '0;
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        bit was_sw;
        bit wset;
        was_sw = eng_active[n] ? m_trig[n] : m_sw[n];
        wset = reg_wr_en && reg_wdata[n];
        m_ack[n] = eng_done[n] && !was_sw;
        if (eng_done[n]) m_sw[n] = 1'b0;
        else if (eng_active[n]) m_sw[n] = m_trig[n];
        if (wset) m_trig[n] = 1'b1;
        else if (eng_active[n]) m_trig[n] = 1'b0;
      end
      m_trig = m_trig & CHMASK;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // One cycle: check registered outputs, drive inputs, check combinational request
  task automatic step(input logic w, input logic [31:0] d, input logic [NUM_CH-1:0] h,
                      input logic [NUM_CH-1:0] a, input logic [NUM_CH-1:0] dn);
    @(negedge clk);
    check("R2 R3 R4 R6 R7 read-back", reg_rdata, m_trig);
    check("R8 R9 R10 acknowledge", 32'(src_ack), 32'(m_ack));
    reg_wr_en = w; reg_wdata = d; hw_req = h; eng_active = a; eng_done = dn;
    #1;
    check("R5 engine request", 32'(eng_req), 32'(m_trig[NUM_CH-1:0] | h));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset read-back", reg_rdata, 32'h0);
    check("R1 reset acknowledge", 32'(src_ack), 32'h0);

    // R2 and R4: set channel 1 and reserved bits
    step(1, 32'hFFFF_FF02, '0, '0, '0);
    step(0, '0, '0, '0, '0);
    check("R4 reserved bits read zero", reg_rdata & ~CHMASK, 32'h0);
    // R3: a zero write keeps channel 1
    step(1, 32'h0000_0004, '0, '0, '0);
    step(0, '0, '0, '0, '0);
    check("R3 zero keeps bit", 32'(reg_rdata[1]), 32'h1);
    // R9: software activation of channel 1 with hw_req also high
    step(0, '0, 8'h02, 8'h02, '0);
    step(0, '0, '0, '0, '0);
    check("R6 trigger cleared", 32'(reg_rdata[1]), 32'h0);
    step(0, '0, '0, '0, 8'h02);
    step(0, '0, '0, '0, '0);
    check("R9 software ack masked", 32'(src_ack[1]), 32'h0);
    // R9 then R8: later hardware activation acknowledges
    step(0, '0, 8'h02, 8'h02, '0);
    step(0, '0, '0, '0, 8'h02);
    step(0, '0, '0, '0, '0);
    check("R8 hardware ack passed", 32'(src_ack[1]), 32'h1);
    // R7: a set write collides with activation on channel 2
    step(0, '0, '0, 8'h04, '0);
    step(1, 32'h0000_0004, '0, 8'h04, '0);
    step(0, '0, '0, '0, '0);
    check("R7 set wins over clear", 32'(reg_rdata[2]), 32'h1);
    // R10: same-cycle activation and completion, software and hardware
    step(0, '0, '0, 8'h0C, 8'h0C);
    step(0, '0, '0, '0, '0);
    check("R10 same-cycle origin", 32'(src_ack[3:2]), 32'h2);

    // Random traffic compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0] == 2'b00, $urandom, NUM_CH'($urandom),
           NUM_CH'($urandom) & NUM_CH'($urandom) & NUM_CH'($urandom),
           NUM_CH'($urandom) & NUM_CH'($urandom) & NUM_CH'($urandom));
    end
    step(0, '0, '0, '0, '0);
    step(0, '0, '0, '0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule